// File: doc/BRIEF.md
# Fixed-Period Winding Current Chopper

This block drives the four gate enables of one H-bridge that feeds one motor winding. It regulates the winding current by chopping at a fixed PWM period. Each period opens with a drive phase in the commanded current direction. Once a blanking interval has passed, the block watches a trip comparator. When the trip fires, the bridge leaves drive and enters a decay phase, which lasts until the period ends. The analog comparator, the current sense path and the reference DAC sit outside the block. It sees only their digital results: a trip flag, a flag saying the winding current is near zero, and a flag saying the commanded current step is falling.

Three decay styles can be selected. Slow decay recirculates the current through both low-side switches. Fast decay drives the bridge in reverse and shuts it off completely once the current nears zero. Mixed decay runs fast until three quarters of the period have passed and slow for the rest, but only on falling-current steps; on rising steps it is plain slow decay. Each leg has its own dead-time stage, so a switch turns on only after both switches of that leg have been off for a fixed number of cycles.

All timing comes from parameters: clock frequency, PWM frequency, blanking time and dead time. The defaults are a 125 MHz clock, a 50 kHz PWM, 3.75 us blanking and 400 ns dead time. With these defaults the period is 2500 cycles, blanking is 468 cycles, the three-quarter point is cycle 1875 and the dead time is 50 cycles.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: Each period begins in drive. With direction 1 the drive pattern is leg A high side on and leg B low side on. With direction 0 it is leg A low side on and leg B high side on.
- R2: The trip input has no effect during the first BLANK cycles of a period, which is also the shortest drive time.
- R3: Once a trip is taken, the bridge stays in decay until the period ends. The next period starts with a new drive phase.
- R4: Slow decay turns on both low-side switches and no high-side switch.
- R5: Fast decay drives the pattern opposite to the drive pattern.
- R6: During fast decay, a near-zero flag turns all four switches off for the rest of the period. The flag has no effect during drive or slow decay.
- R7: In mixed decay on a falling step, the bridge uses fast decay before cycle MIX (three quarters of the period) and slow decay from that cycle on.
- R8: In mixed decay on a rising step (falling flag 0), the bridge uses slow decay.
- R9: Decay select 2'b00 is slow, 2'b11 is fast, and both 2'b01 and 2'b10 (the undriven middle level) are mixed. Direction, decay select and the falling flag are sampled on the cycle before each period starts, and on every cycle while the block is disabled.
- R10: Reset forces all four switches off. While enable is low, all four switches are off from the next cycle on. Raising enable starts a new period.
- R11: A switch turns on only after both switches of its leg have been off for at least DEAD cycles. The high and low switch of a leg are never on together.
- R12: If no trip is taken in a period, drive lasts for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bridge enable; low turns all switches off |
| dir | input | 1 | Commanded current sign |
| trip | input | 1 | Current trip comparator result |
| near_zero | input | 1 | Winding current is near zero |
| i_falling | input | 1 | The commanded current step is falling |
| decay_sel | input | 2 | Decay style: 00 slow, 01/10 mixed, 11 fast |
| gate_a_hi | output | 1 | Leg A high-side switch enable |
| gate_a_lo | output | 1 | Leg A low-side switch enable |
| gate_b_hi | output | 1 | Leg B high-side switch enable |
| gate_b_lo | output | 1 | Leg B low-side switch enable |

## Verification
The assertions assume that reset and enable are synchronous to the clock. The trip and near-zero flags may change on any cycle, and the properties still hold for any pattern of those flags. Direction, decay select and the falling flag are sampled only at period edges, so a change mid-period has no effect. For this reason the stimulus holds each of them constant through a whole enabled run. The stimulus places trip pulses inside the blanking window, after it, and never in a period. It asserts near-zero during fast decay, during slow decay and after the mixed switch point. No sample is checked within a few dead times of any decay change, so the checks look only at settled switch patterns.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_cmd_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_MIX_A = 2'b01,
    DK_MIX_B = 2'b10,
    DK_FAST  = 2'b11
  } decay_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DRIVE,
    PH_SLOW,
    PH_FAST
  } phase_e;

  typedef struct packed {
    leg_cmd_e a;
    leg_cmd_e b;
  } bridge_cmd_t;

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD = 2500,
  parameter int BLANK  = 468,
  parameter int MIX    = 1875,
  localparam int CW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          load,
  output logic          past_blank,
  output logic          past_mix
);

  // load marks the last cycle before a period begins (or any disabled cycle)
  assign load       = !en || (cnt == CW'(PERIOD - 1));
  assign past_blank = (cnt >= CW'(BLANK));
  assign past_mix   = (cnt >= CW'(MIX));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/chop_decay_ctrl.sv
module chop_decay_ctrl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        load,
  input  logic        past_blank,
  input  logic        past_mix,
  input  logic        dir,
  input  logic        trip,
  input  logic        near_zero,
  input  logic        i_falling,
  input  logic [1:0]  decay_sel,
  output bridge_cmd_t cmd,
  output logic        tripped
);

  logic       dir_q;
  logic       fall_q;
  logic       zero_q;
  decay_sel_e sel_q;
  phase_e     phase;

  // Per-period state: command sampled at period edge, trip and zero latches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      fall_q  <= 1'b0;
      sel_q   <= DK_MIX_A;
      tripped <= 1'b0;
      zero_q  <= 1'b0;
    end else if (load) begin
      dir_q   <= dir;
      fall_q  <= i_falling;
      sel_q   <= decay_sel_e'(decay_sel);
      tripped <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (past_blank && trip)         tripped <= 1'b1;
      if (phase == PH_FAST && near_zero) zero_q <= 1'b1;
    end
  end

  always_comb begin
    if (!en)          phase = PH_IDLE;
    else if (!tripped) phase = PH_DRIVE;
    else begin
      unique case (sel_q)
        DK_SLOW: phase = PH_SLOW;
        DK_FAST: phase = PH_FAST;
        default: phase = (fall_q && !past_mix) ? PH_FAST : PH_SLOW;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_DRIVE: cmd = dir_q ? '{a: LEG_HI, b: LEG_LO} : '{a: LEG_LO, b: LEG_HI};
      PH_FAST: begin
        if (zero_q)     cmd = '{a: LEG_OFF, b: LEG_OFF};
        else if (dir_q) cmd = '{a: LEG_LO, b: LEG_HI};
        else            cmd = '{a: LEG_HI, b: LEG_LO};
      end
      PH_SLOW:  cmd = '{a: LEG_LO, b: LEG_LO};
      default:  cmd = '{a: LEG_OFF, b: LEG_OFF};
    endcase
  end

endmodule

// File: rtl/chop_leg_driver.sv
module chop_leg_driver
  import chop_pkg::*;
#(
  parameter int DEAD  = 50,
  localparam int DW   = $clog2(DEAD + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_e req,
  output logic     hi,
  output logic     lo
);

  leg_cmd_e       act;
  logic [DW-1:0]  off_cnt;

  // Any change first drops the leg to off, then waits DEAD off cycles
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= LEG_OFF;
      off_cnt <= '0;
    end else if (act != LEG_OFF) begin
      if (req != act) begin
        act     <= LEG_OFF;
        off_cnt <= '0;
      end
    end else begin
      if (req != LEG_OFF && off_cnt == DW'(DEAD)) act <= req;
      else if (off_cnt != DW'(DEAD))               off_cnt <= off_cnt + 1'b1;
    end
  end

  assign hi = (act == LEG_HI);
  assign lo = (act == LEG_LO);

endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int PWM_HZ   = 50_000,
  parameter int BLANK_NS = 3750,
  parameter int DEAD_NS  = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       dir,
  input  logic       trip,
  input  logic       near_zero,
  input  logic       i_falling,
  input  logic [1:0] decay_sel,
  output logic       gate_a_hi,
  output logic       gate_a_lo,
  output logic       gate_b_hi,
  output logic       gate_b_lo
);

  localparam int PERIOD = CLK_HZ / PWM_HZ;
  localparam int BLANK  = (CLK_HZ / 1000) * BLANK_NS / 1_000_000;
  localparam int DEAD   = (CLK_HZ / 1000) * DEAD_NS / 1_000_000;
  localparam int MIX    = (PERIOD * 3) / 4;
  localparam int CW     = $clog2(PERIOD);
  localparam int NLEG   = 2;

  logic [CW-1:0] cnt_q;
  logic          load;
  logic          past_blank;
  logic          past_mix;
  logic          tripped_q;
  bridge_cmd_t   cmd;
  leg_cmd_e      leg_req [NLEG];
  logic [NLEG-1:0] hi_v;
  logic [NLEG-1:0] lo_v;

  chop_period_timer #(
    .PERIOD (PERIOD),
    .BLANK  (BLANK),
    .MIX    (MIX)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt        (cnt_q),
    .load       (load),
    .past_blank (past_blank),
    .past_mix   (past_mix)
  );

  chop_decay_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .load       (load),
    .past_blank (past_blank),
    .past_mix   (past_mix),
    .dir        (dir),
    .trip       (trip),
    .near_zero  (near_zero),
    .i_falling  (i_falling),
    .decay_sel  (decay_sel),
    .cmd        (cmd),
    .tripped    (tripped_q)
  );

  assign leg_req[0] = cmd.a;
  assign leg_req[1] = cmd.b;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    chop_leg_driver #(
      .DEAD (DEAD)
    ) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (leg_req[g]),
      .hi    (hi_v[g]),
      .lo    (lo_v[g])
    );
  end

  assign gate_a_hi = hi_v[0];
  assign gate_a_lo = lo_v[0];
  assign gate_b_hi = hi_v[1];
  assign gate_b_lo = lo_v[1];

endmodule

// File: rtl/chop_bridge_ctrl_chk.sv
module chop_bridge_ctrl_chk #(
  parameter int PERIOD = 2500,
  parameter int BLANK  = 468,
  parameter int DEAD   = 50,
  localparam int CW    = $clog2(PERIOD),
  localparam int OW    = $clog2(DEAD + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          load,
  input logic [CW-1:0] cnt,
  input logic          tripped,
  input logic          gate_a_hi,
  input logic          gate_a_lo,
  input logic          gate_b_hi,
  input logic          gate_b_lo
);

  logic [OW-1:0] off_a;
  logic [OW-1:0] off_b;

  // Count consecutive both-off cycles per leg, saturating above DEAD
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_a <= '0;
      off_b <= '0;
    end else begin
      if (gate_a_hi || gate_a_lo)     off_a <= '0;
      else if (off_a != OW'(DEAD + 1)) off_a <= off_a + 1'b1;
      if (gate_b_hi || gate_b_lo)     off_b <= '0;
      else if (off_b != OW'(DEAD + 1)) off_b <= off_b + 1'b1;
    end
  end

  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_hi && gate_a_lo) && !(gate_b_hi && gate_b_lo));

  p_dead_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_a_hi || gate_a_lo) |-> (off_a >= OW'(DEAD)));

  p_dead_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_b_hi || gate_b_lo) |-> (off_b >= OW'(DEAD)));

  p_off_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));

  p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> ($past(cnt) >= CW'(BLANK)));

  p_hold_decay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !load) |=> tripped);

  p_new_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tripped);

  p_count_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PERIOD));

endmodule

bind chop_bridge_ctrl chop_bridge_ctrl_chk #(
  .PERIOD (PERIOD),
  .BLANK  (BLANK),
  .DEAD   (DEAD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .load      (load),
  .cnt       (cnt_q),
  .tripped   (tripped_q),
  .gate_a_hi (gate_a_hi),
  .gate_a_lo (gate_a_lo),
  .gate_b_hi (gate_b_hi),
  .gate_b_lo (gate_b_lo)
);

// File: tb/tb_chop_bridge_ctrl.sv
module tb_chop_bridge_ctrl;

  localparam int PERIOD = 2500;
  localparam int BLANK  = 468;
  localparam int MIX    = 1875;
  localparam int DEAD   = 50;
  localparam int NEVER  = 99999;
  localparam int GUARD  = 70;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dir = 1'b0;
  logic       trip = 1'b0;
  logic       near_zero = 1'b0;
  logic       i_falling = 1'b0;
  logic [1:0] decay_sel = 2'b01;
  logic       gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

  int n_checks = 0;
  int n_errors = 0;
  int dead_viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chop_bridge_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dir       (dir),
    .trip      (trip),
    .near_zero (near_zero),
    .i_falling (i_falling),
    .decay_sel (decay_sel),
    .gate_a_hi (gate_a_hi),
    .gate_a_lo (gate_a_lo),
    .gate_b_hi (gate_b_hi),
    .gate_b_lo (gate_b_lo)
  );

  function automatic logic [3:0] gates();
    return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: gates actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // R11 monitor: off run before each switch-on, and no shoot-through
  int run_a = 0;
  int run_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) dead_viol++;
      if (gate_a_hi || gate_a_lo) begin
        if (run_a > 0 && run_a < DEAD) dead_viol++;
        run_a = 0;
      end else run_a++;
      if (gate_b_hi || gate_b_lo) begin
        if (run_b > 0 && run_b < DEAD) dead_viol++;
        run_b = 0;
      end else run_b++;
    end
  end

  // Expected settled pattern at offset o after enable, from the requirements
  function automatic void expect_at(input bit d, input logic [1:0] s, input bit f,
                                    input int tt, input int tz, input int o,
                                    output logic [3:0] g, output string tag);
    int pos;
    bit trip_ok, mixed, fast_now, zero_eff;
    logic [3:0] drv, rev;
    pos     = o % PERIOD;
    trip_ok = (tt >= BLANK) && (tt < PERIOD);
    mixed   = (s == 2'b01) || (s == 2'b10);
    drv     = d ? 4'b1001 : 4'b0110;
    rev     = d ? 4'b0110 : 4'b1001;
    if (o >= PERIOD) begin g = drv; tag = "R3"; return; end
    if (!trip_ok || pos < tt) begin
      g = drv;
      tag = (tt < BLANK) ? "R2" : (trip_ok ? "R1" : "R12");
      return;
    end
    fast_now = (s == 2'b11) || (mixed && f && pos < MIX);
    zero_eff = (tz > tt) && (tz < PERIOD) && ((s == 2'b11) || (mixed && f && tz < MIX));
    if (fast_now) begin
      if (zero_eff && pos > tz) begin g = 4'b0000; tag = "R6"; end
      else begin g = rev; tag = mixed ? "R7" : "R5"; end
    end else begin
      g = 4'b0101;
      tag = (s == 2'b00) ? "R4" : (f ? "R7" : "R8");
    end
    if (s == 2'b10 && tag != "R6") tag = "R9";
  endfunction

  function automatic bit near_evt(input int pos, input int e);
    return (pos + GUARD > e) && (pos < e + GUARD);
  endfunction

  task automatic scenario(input bit d, input logic [1:0] s, input bit f, input int tt, input int tz);
    logic [3:0] g;
    string tag;
    int pos;
    en = 1'b0;
    dir = d; decay_sel = s; i_falling = f;
    trip = 1'b0; near_zero = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", gates(), 4'b0000);
    repeat (DEAD) @(negedge clk);
    en = 1'b1;
    for (int o = 0; o < 2 * PERIOD; o++) begin
      trip      = (o < PERIOD) && (o >= tt) && (o < tt + 3);
      near_zero = (o < PERIOD) && (o >= tz) && (o < tz + 3);
      pos = o % PERIOD;
      if (o % 97 == 50 && !near_evt(pos, 0) && !near_evt(pos, PERIOD) &&
          !near_evt(pos, MIX) && !(o < PERIOD && (near_evt(pos, tt) || near_evt(pos, tz)))) begin
        expect_at(d, s, f, tt, tz, o, g, tag);
        check(tag, gates(), g);
      end
      @(negedge clk);
    end
    trip = 1'b0; near_zero = 1'b0;
  endtask

  initial begin
    int tt, tz;
    void'($urandom(32'd5150));
    repeat (10) @(negedge clk);
    check("R10", gates(), 4'b0000);
    rst_n = 1'b1;
    // directed corner cases
    scenario(1'b1, 2'b00, 1'b0, 1000, NEVER);  // R4 slow
    scenario(1'b1, 2'b11, 1'b0, 900, 1500);    // R5 fast, R6 zero cut
    scenario(1'b0, 2'b01, 1'b1, 800, NEVER);   // R7 mixed falling
    scenario(1'b0, 2'b10, 1'b0, 1200, NEVER);  // R8 / R9 mixed rising
    scenario(1'b1, 2'b01, 1'b1, 600, 1000);    // R7 with zero then slow
    scenario(1'b0, 2'b00, 1'b0, 200, NEVER);   // R2 trip inside blanking
    scenario(1'b1, 2'b11, 1'b0, NEVER, NEVER); // R12 no trip
    scenario(1'b0, 2'b11, 1'b0, 1000, NEVER);  // R5 negative direction
    scenario(1'b1, 2'b00, 1'b1, 1000, 1300);   // R6 zero ignored in slow
    // constrained random
    for (int k = 0; k < 14; k++) begin
      tt = BLANK + 30 + int'($urandom % (PERIOD - BLANK - 150));
      if (tt > MIX - 80 && tt < MIX + 80) tt -= 160;
      tz = tt + 100 + int'($urandom % 600);
      if (tz > PERIOD - 100) tz = NEVER;
      else if (tz > MIX - 5 && tz < MIX + 5) tz += 10;
      scenario(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), tt, tz);
    end
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", gates(), 4'b0000);
    n_checks++;
    if (dead_viol != 0) begin
      n_errors++;
      $display("FAIL R11: dead-time violations actual %0d expected 0", dead_viol);
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule